// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Four-Lane Line Conditioner

This block is the control-plane endpoint of a four-lane line conditioner. It listens on a two-wire serial management bus (clock line and open-drain data line) and serves a small bank of byte registers. The register outputs steer the lane datapaths: a disable flag and a boost code per lane, a signal-detect threshold pair per lane, a bit that hands enable control to the registers, and a shared output swing code. One register reflects the four live signal-detect flags from the lanes.

Both bus lines are oversampled on the system clock, which must run at least 16 times faster than the bus clock. Each line passes through a two-flop synchronizer before edges, START and STOP are decoded. The slave only takes part while the active-high chip-select input is high. A host writes one register with a three-byte transfer. It reads one register by writing the pointer, issuing a repeated START and clocking in the data byte. The only drive onto the bus is an enable that pulls the data line low.

Top module: `lcfg_slave`

## Requirements
- R1: After reset, every lane has its disable flag at 0 and boost code 3'b100, so lane_boost reads 12'h924. Both threshold select outputs read 0, reg_en_mode is 0 and drive_level is 2'b10. Registers 0x03 and 0x04 read back 0x44 and register 0x08 reads back 0x78.
- R2: A write is START, then 0xAC (7-bit address 1010110 with write bit 0), the register pointer and one data byte, then STOP. The slave pulls the data line low in the ACK slot after each of the three bytes, and the addressed register holds the data byte afterwards.
- R3: A read is START, 0xAC, the pointer, a repeated START and 0xAD. The slave then shifts out the register at the pointer, MSB first, and changes the data line only while the clock line is low. The pointer set by the write phase is the one used by the read.
- R4: An address byte whose upper seven bits differ from 1010110 gets no ACK. The bytes after it get no ACK and change no register.
- R5: While cs is low the slave never drives the data line, and bus traffic changes no register.
- R6: Register 0x02 returns sig_det in bits 3:0 (lane 3 in bit 3) and zeros above, sampled when the read starts. Registers 0x00, 0x01 and 0x02 are read-only: a write to them is ACKed and has no effect, and 0x00 and 0x01 read 0x00.
- R7: A write to an address above 0x08 is ACKed and discarded. A read of such an address returns 0x00.
- R8: A START at any point abandons the transfer in progress and begins address reception. After a STOP, bytes sent without a new START are not ACKed.
- R9: If both lines stay high for more than IDLE_CYCLES (64) system clocks, the slave drops back to idle. Bytes sent after that without a new START are not ACKed and are not stored.
- R10: In registers 0x03 and 0x04, bit 7 is the disable flag of the odd lane and bits 6:4 are its boost. Bit 3 is the disable flag of the even lane and bits 2:0 are its boost. Register 0x03 serves lanes 1/0 and 0x04 serves lanes 3/2. The 0x05 and 0x06 bytes drive det_on_sel and det_off_sel directly. Bit 0 of 0x07 drives reg_en_mode, and bits 3:2 of 0x08 drive drive_level.
- R11: Only one data byte is taken per write. A second data byte before STOP is not ACKed and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, high enables bus participation |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sig_det | input | 4 | Live per-lane signal-detect flags |
| sda_oe | output | 1 | High pulls the bus data line low |
| lane_dis | output | 4 | Per-lane disable flags |
| lane_boost | output | 12 | Per-lane boost codes, 3 bits each, lane 0 lowest |
| det_on_sel | output | 8 | Signal-detect assert threshold selects, 2 bits per lane |
| det_off_sel | output | 8 | Signal-detect deassert threshold selects, 2 bits per lane |
| reg_en_mode | output | 1 | Lane enables taken from registers when high |
| drive_level | output | 2 | Output swing code shared by all lanes |

## Verification
A protocol state machine that has lost its place shows up within one byte time. The ACK slot of the next byte is pulled low when it should float, or floats when it should be pulled low. Read data, which the slave shifts out one bit per clock-line fall, shows a bit-count or ordering fault as a wrong byte at the host in the same transfer. A register-decode fault appears on the lane control outputs one system clock after the data byte's eighth bit is taken in, and again in a later read-back. A missed START, STOP or idle timeout becomes visible when bytes sent without a fresh START are ACKed or change an output.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_DEV,
      PS_PTR,
      PS_DATA,
      PS_ACK,
      PS_TX,
      PS_MACK
   } proto_st_e;

   localparam logic [7:0] RA_ID    = 8'h00;
   localparam logic [7:0] RA_REV   = 8'h01;
   localparam logic [7:0] RA_STAT  = 8'h02;
   localparam logic [7:0] RA_PAIR0 = 8'h03;
endpackage

// File: rtl/lcfg_sync.sv
module lcfg_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcfg_sync needs at least two stages");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {CHAIN_W{RST_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/lcfg_linemon.sv
module lcfg_linemon #(
   parameter int IDLE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic idle_hit
);
   localparam int CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

   if (IDLE_CYCLES < 16) begin : g_bad_idle
      $error("lcfg_linemon idle window too short");
   end

   logic scl_p, sda_p;
   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
         hi_cnt <= '0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (!(scl_s && sda_s))  hi_cnt <= '0;
         else if (hi_cnt != LIMIT) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
   assign idle_hit  = (hi_cnt == LIMIT);
endmodule

// File: rtl/lcfg_proto.sv
module lcfg_proto import lcfg_pkg::*; #(
   parameter logic [6:0] DEV_ADDR = 7'b1010110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       idle_hit,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic [7:0] ptr,
   output logic       wr_en,
   output logic [7:0] wr_data
);
   proto_st_e  st, nxt;
   logic [3:0] cnt;
   logic [7:0] shreg, txsh;
   logic       oe_q;
   logic [7:0] ptr_q;
   logic       byte_done;

   assign byte_done = scl_fall && (cnt == 4'd8);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= PS_IDLE;
         nxt   <= PS_IDLE;
         cnt   <= '0;
         shreg <= '0;
         txsh  <= '0;
         oe_q  <= 1'b0;
         ptr_q <= '0;
      end else if (!cs) begin
         st   <= PS_IDLE;
         oe_q <= 1'b0;
      end else if (start_det) begin
         st   <= PS_DEV;
         cnt  <= '0;
         oe_q <= 1'b0;
      end else if (stop_det || idle_hit) begin
         st   <= PS_IDLE;
         oe_q <= 1'b0;
      end else begin
         case (st)
            PS_DEV, PS_PTR, PS_DATA: begin
               if (scl_rise) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 4'd1;
               end else if (byte_done) begin
                  if (st == PS_DEV) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        oe_q <= 1'b1;
                        nxt  <= shreg[0] ? PS_TX : PS_PTR;
                        st   <= PS_ACK;
                     end else begin
                        st <= PS_IDLE;
                     end
                  end else if (st == PS_PTR) begin
                     ptr_q <= shreg;
                     oe_q  <= 1'b1;
                     nxt   <= PS_DATA;
                     st    <= PS_ACK;
                  end else begin
                     oe_q <= 1'b1;
                     nxt  <= PS_IDLE;
                     st   <= PS_ACK;
                  end
               end
            end
            PS_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  st  <= nxt;
                  if (nxt == PS_TX) begin
                     oe_q <= ~rd_data[7];
                     txsh <= {rd_data[6:0], 1'b0};
                  end else begin
                     oe_q <= 1'b0;
                  end
               end
            end
            PS_TX: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     oe_q <= 1'b0;
                     st   <= PS_MACK;
                  end else begin
                     oe_q <= ~txsh[7];
                     txsh <= {txsh[6:0], 1'b0};
                     cnt  <= cnt + 4'd1;
                  end
               end
            end
            PS_MACK: begin
               if (scl_fall) st <= PS_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign wr_en   = cs && (st == PS_DATA) && byte_done;
   assign wr_data = shreg;
   assign ptr     = ptr_q;
   assign sda_oe  = oe_q;
endmodule

// File: rtl/lcfg_regs.sv
module lcfg_regs import lcfg_pkg::*; #(
   parameter int NUM_CH  = 4,
   parameter int BOOST_W = 3,
   parameter logic [7:0] PAIR_RST  = 8'h44,
   parameter logic [7:0] CTRL_RST  = 8'h00,
   parameter logic [7:0] LEVEL_RST = 8'h78
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:0]              addr,
   input  logic [7:0]              wr_data,
   input  logic [NUM_CH-1:0]       sig_det,
   output logic [7:0]              rd_data,
   output logic [NUM_CH-1:0]       lane_dis,
   output logic [NUM_CH*BOOST_W-1:0] lane_boost,
   output logic [2*NUM_CH-1:0]     det_on_sel,
   output logic [2*NUM_CH-1:0]     det_off_sel,
   output logic                    reg_en_mode,
   output logic [1:0]              drive_level
);
   localparam int NUM_PAIR = NUM_CH / 2;
   localparam int HALF     = BOOST_W + 1;
   localparam int SEL_W    = 2 * NUM_CH;
   localparam logic [7:0] A_ON   = RA_PAIR0 + 8'(NUM_PAIR);
   localparam logic [7:0] A_OFF  = A_ON + 8'd1;
   localparam logic [7:0] A_CTRL = A_OFF + 8'd1;
   localparam logic [7:0] A_LVL  = A_CTRL + 8'd1;

   if ((NUM_CH % 2) != 0 || NUM_CH > 4 || NUM_CH < 2) begin : g_bad_ch
      $error("lcfg_regs lane count must be 2 or 4");
   end
   if (2 * HALF != 8) begin : g_bad_boost
      $error("lcfg_regs two lane fields must fill one byte");
   end

   logic [7:0]       pair_all [NUM_PAIR];
   logic [SEL_W-1:0] on_q, off_q;
   logic [7:0]       ctrl_q, lvl_q;

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      localparam logic [7:0] MY_A = RA_PAIR0 + 8'(p);
      logic [7:0] pair_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                      pair_q <= PAIR_RST;
         else if (wr_en && addr == MY_A)  pair_q <= wr_data;
      end
      assign pair_all[p] = pair_q;
      assign lane_dis[2*p]                      = pair_q[HALF-1];
      assign lane_boost[2*p*BOOST_W +: BOOST_W] = pair_q[BOOST_W-1:0];
      assign lane_dis[2*p+1]                    = pair_q[2*HALF-1];
      assign lane_boost[(2*p+1)*BOOST_W +: BOOST_W] = pair_q[HALF +: BOOST_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q   <= '0;
         off_q  <= '0;
         ctrl_q <= CTRL_RST;
         lvl_q  <= LEVEL_RST;
      end else if (wr_en) begin
         if (addr == A_ON)   on_q   <= wr_data[SEL_W-1:0];
         if (addr == A_OFF)  off_q  <= wr_data[SEL_W-1:0];
         if (addr == A_CTRL) ctrl_q <= wr_data;
         if (addr == A_LVL)  lvl_q  <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == RA_STAT)      rd_data[NUM_CH-1:0] = sig_det;
      else if (addr == A_ON)    rd_data[SEL_W-1:0]  = on_q;
      else if (addr == A_OFF)   rd_data[SEL_W-1:0]  = off_q;
      else if (addr == A_CTRL)  rd_data             = ctrl_q;
      else if (addr == A_LVL)   rd_data             = lvl_q;
      for (int i = 0; i < NUM_PAIR; i++) begin
         if (addr == RA_PAIR0 + 8'(i)) rd_data = pair_all[i];
      end
   end

   assign det_on_sel  = on_q;
   assign det_off_sel = off_q;
   assign reg_en_mode = ctrl_q[0];
   assign drive_level = lvl_q[3:2];
endmodule

// File: rtl/lcfg_slave.sv
module lcfg_slave import lcfg_pkg::*; #(
   parameter int NUM_CH      = 4,
   parameter int BOOST_W     = 3,
   parameter logic [6:0] DEV_ADDR = 7'b1010110,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_CYCLES = 64,
   parameter logic [7:0] PAIR_RST  = 8'h44,
   parameter logic [7:0] CTRL_RST  = 8'h00,
   parameter logic [7:0] LEVEL_RST = 8'h78
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs,
   input  logic                      scl_i,
   input  logic                      sda_i,
   input  logic [NUM_CH-1:0]         sig_det,
   output logic                      sda_oe,
   output logic [NUM_CH-1:0]         lane_dis,
   output logic [NUM_CH*BOOST_W-1:0] lane_boost,
   output logic [2*NUM_CH-1:0]       det_on_sel,
   output logic [2*NUM_CH-1:0]       det_off_sel,
   output logic                      reg_en_mode,
   output logic [1:0]                drive_level
);
   logic [1:0] lines_s;
   logic scl_rise, scl_fall, start_det, stop_det, idle_hit;
   logic [7:0] rd_data, ptr, wr_data;
   logic wr_en;

   lcfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
   );

   lcfg_linemon #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .idle_hit(idle_hit)
   );

   lcfg_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sda_s(lines_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .idle_hit(idle_hit), .rd_data(rd_data),
      .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data)
   );

   lcfg_regs #(
      .NUM_CH(NUM_CH), .BOOST_W(BOOST_W), .PAIR_RST(PAIR_RST),
      .CTRL_RST(CTRL_RST), .LEVEL_RST(LEVEL_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
      .sig_det(sig_det), .rd_data(rd_data), .lane_dis(lane_dis),
      .lane_boost(lane_boost), .det_on_sel(det_on_sel), .det_off_sel(det_off_sel),
      .reg_en_mode(reg_en_mode), .drive_level(drive_level)
   );
endmodule

// File: rtl/lcfg_slave_chk.sv
module lcfg_slave_chk #(
   parameter int NUM_CH  = 4,
   parameter int BOOST_W = 3,
   parameter logic [7:0] LEVEL_RST = 8'h78
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cs,
   input logic                      scl_i,
   input logic                      sda_oe,
   input logic [NUM_CH-1:0]         lane_dis,
   input logic [NUM_CH*BOOST_W-1:0] lane_boost,
   input logic [2*NUM_CH-1:0]       det_on_sel,
   input logic                      reg_en_mode,
   input logic [1:0]                drive_level
);
   AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lane_dis == '0 && !reg_en_mode && drive_level == LEVEL_RST[3:2])); // R1

   AST_CS_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !sda_oe); // R5

   AST_CS_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cs) |-> ($stable(lane_dis) && $stable(lane_boost) && $stable(det_on_sel)
                      && $stable(reg_en_mode) && $stable(drive_level))); // R5

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs) && cs && !$stable(sda_oe)) |-> !scl_i); // R3
endmodule

bind lcfg_slave lcfg_slave_chk #(
   .NUM_CH(NUM_CH), .BOOST_W(BOOST_W), .LEVEL_RST(LEVEL_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .scl_i(scl_i), .sda_oe(sda_oe),
   .lane_dis(lane_dis), .lane_boost(lane_boost), .det_on_sel(det_on_sel),
   .reg_en_mode(reg_en_mode), .drive_level(drive_level)
);

// File: tb/tb_lcfg_slave.sv
module tb_lcfg_slave;
   localparam int Q = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b1;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [3:0] sig_det = 4'b0000;
   logic sda_oe;
   logic [3:0] lane_dis;
   logic [11:0] lane_boost;
   logic [7:0] det_on_sel, det_off_sel;
   logic reg_en_mode;
   logic [1:0] drive_level;
   logic sda_w;

   always #2 clk = ~clk;

   assign sda_w = m_sda & ~sda_oe;

   lcfg_slave dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .scl_i(m_scl), .sda_i(sda_w),
      .sig_det(sig_det), .sda_oe(sda_oe), .lane_dis(lane_dis),
      .lane_boost(lane_boost), .det_on_sel(det_on_sel), .det_off_sel(det_off_sel),
      .reg_en_mode(reg_en_mode), .drive_level(drive_level)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string tag_q[$];
   int exp_q[$];
   int obs_q[$];

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(string tag, int e);
      tag_q.push_back(tag);
      exp_q.push_back(e);
   endtask

   task automatic push_obs(int a);
      obs_q.push_back(a);
   endtask

   task automatic chk(string tag, int e, int a);
      push_exp(tag, e);
      push_obs(a);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0 && obs_q.size() > 0) begin
            string t;
            int e, a;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            a = obs_q.pop_front();
            n_run++;
            if (e != a) begin
               n_fail++;
               $display("FAIL %s actual=%0h expected=%0h", t, a, e);
            end
         end
      end
   end

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_sda = 1'b0; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_sda = 1'b1; tick(2*Q);
   endtask

   task automatic send_bit(bit b);
      m_sda = b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output bit b);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = sda_w; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(logic [7:0] v, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(ack);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         bit b;
         recv_bit(b);
         v[i] = b;
      end
   endtask

   // exp_ack holds the ACK-slot line level expected per byte (0 = pulled low)
   task automatic wr(logic [7:0] dev, logic [7:0] ptr, logic [7:0] dat,
                     logic [2:0] exp_ack, string tag);
      bit a;
      bus_start();
      send_byte(dev, a); chk({tag, " ack dev"}, int'(exp_ack[2]), int'(a));
      send_byte(ptr, a); chk({tag, " ack ptr"}, int'(exp_ack[1]), int'(a));
      send_byte(dat, a); chk({tag, " ack dat"}, int'(exp_ack[0]), int'(a));
      bus_stop();
   endtask

   task automatic rd(logic [7:0] ptr, logic [7:0] expv, string tag);
      bit a;
      logic [7:0] v;
      bus_start();
      send_byte(8'hAC, a); chk({tag, " rd ack dev"}, 0, int'(a));
      send_byte(ptr, a);   chk({tag, " rd ack ptr"}, 0, int'(a));
      bus_start();
      send_byte(8'hAD, a); chk({tag, " rd ack devr"}, 0, int'(a));
      recv_byte(v);
      push_exp({tag, " rd data"}, int'(expv));
      push_obs(int'(v));
      send_bit(1'b1);
      bus_stop();
   endtask

   initial begin
      bit a;
      tick(5);
      rst_n = 1'b1;
      tick(3);

      // R1 reset state at the ports
      chk("R1 lane_dis", 0, int'(lane_dis));
      chk("R1 lane_boost", 'h924, int'(lane_boost));
      chk("R1 det_on_sel", 0, int'(det_on_sel));
      chk("R1 det_off_sel", 0, int'(det_off_sel));
      chk("R1 reg_en_mode", 0, int'(reg_en_mode));
      chk("R1 drive_level", 2, int'(drive_level));
      chk("R1 sda_oe", 0, int'(sda_oe));
      rd(8'h03, 8'h44, "R1 reg03");
      rd(8'h08, 8'h78, "R1 reg08");

      // R2 / R10 writes and output mapping
      wr(8'hAC, 8'h03, 8'hB5, 3'b000, "R2");
      chk("R10 lane_dis after 03", 'h2, int'(lane_dis));
      chk("R10 lane_boost after 03", 'h91D, int'(lane_boost));
      wr(8'hAC, 8'h04, 8'h2F, 3'b000, "R2");
      chk("R10 lane_dis after 04", 'h6, int'(lane_dis));
      chk("R10 lane_boost after 04", 'h5DD, int'(lane_boost));
      rd(8'h03, 8'hB5, "R3 reg03");
      wr(8'hAC, 8'h05, 8'hA5, 3'b000, "R2");
      wr(8'hAC, 8'h06, 8'h3C, 3'b000, "R2");
      wr(8'hAC, 8'h07, 8'h01, 3'b000, "R2");
      wr(8'hAC, 8'h08, 8'h0C, 3'b000, "R2");
      chk("R10 det_on_sel", 'hA5, int'(det_on_sel));
      chk("R10 det_off_sel", 'h3C, int'(det_off_sel));
      chk("R10 reg_en_mode", 1, int'(reg_en_mode));
      chk("R10 drive_level", 3, int'(drive_level));
      rd(8'h08, 8'h0C, "R3 reg08");

      // R6 live status and read-only registers
      sig_det = 4'b1001;
      rd(8'h02, 8'h09, "R6 stat a");
      sig_det = 4'b0110;
      rd(8'h02, 8'h06, "R6 stat b");
      wr(8'hAC, 8'h02, 8'hFF, 3'b000, "R6 ro02");
      rd(8'h02, 8'h06, "R6 stat kept");
      wr(8'hAC, 8'h00, 8'h55, 3'b000, "R6 ro00");
      rd(8'h00, 8'h00, "R6 reg00");
      wr(8'hAC, 8'h01, 8'h55, 3'b000, "R6 ro01");
      rd(8'h01, 8'h00, "R6 reg01");

      // R7 unimplemented addresses
      wr(8'hAC, 8'h20, 8'hAA, 3'b000, "R7 wr20");
      rd(8'h20, 8'h00, "R7 rd20");
      rd(8'h09, 8'h00, "R7 rd09");
      chk("R7 lane_boost kept", 'h5DD, int'(lane_boost));
      chk("R7 det_on_sel kept", 'hA5, int'(det_on_sel));

      // R4 address mismatch
      wr(8'hAE, 8'h05, 8'h00, 3'b111, "R4");
      chk("R4 det_on_sel kept", 'hA5, int'(det_on_sel));

      // R5 chip select low
      cs = 1'b0;
      tick(2);
      wr(8'hAC, 8'h05, 8'h00, 3'b111, "R5");
      chk("R5 det_on_sel kept", 'hA5, int'(det_on_sel));
      cs = 1'b1;
      tick(2);

      // R11 second data byte refused
      bus_start();
      send_byte(8'hAC, a); chk("R11 ack dev", 0, int'(a));
      send_byte(8'h06, a); chk("R11 ack ptr", 0, int'(a));
      send_byte(8'h11, a); chk("R11 ack d1", 0, int'(a));
      send_byte(8'h22, a); chk("R11 ack d2", 1, int'(a));
      bus_stop();
      chk("R11 det_off_sel", 'h11, int'(det_off_sel));

      // R9 idle timeout mid-transfer
      bus_start();
      send_byte(8'hAC, a); chk("R9 ack dev", 0, int'(a));
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(100);
      m_scl = 1'b0; tick(Q);
      send_byte(8'h05, a); chk("R9 ack ptr", 1, int'(a));
      send_byte(8'h00, a); chk("R9 ack dat", 1, int'(a));
      bus_stop();
      chk("R9 det_on_sel kept", 'hA5, int'(det_on_sel));

      // R8 STOP then bytes without START
      bus_start();
      send_byte(8'hAC, a); chk("R8 ack dev", 0, int'(a));
      send_byte(8'h08, a); chk("R8 ack ptr", 0, int'(a));
      bus_stop();
      m_scl = 1'b0; tick(Q);
      send_byte(8'h00, a); chk("R8 ack after stop", 1, int'(a));
      bus_stop();
      chk("R8 drive_level kept", 3, int'(drive_level));

      // R8 START in the middle of a byte restarts
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      wr(8'hAC, 8'h07, 8'h00, 3'b000, "R8 restart");
      chk("R8 reg_en_mode", 0, int'(reg_en_mode));

      tick(4);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule